// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block turns a free-running oscillator into the timing of a small microcontroller core. A two-bit phase counter splits every four oscillator clocks into one instruction cycle with four one-hot phase strobes (Q1 to Q4). These phases drive a two-stage pipeline: while one instruction word executes out of the instruction register, the next word is fetched from program memory. Fetching and execution overlap, so straight-line code completes one instruction per instruction cycle.

The sequencer owns the program counter, the fetch address presented to program memory, the instruction register, and the data-memory read and write slot strobes. The execute logic outside the block asks for a control transfer with a branch request and a target address. A separate interrupt request is taken only at an instruction-cycle boundary. Both kinds of transfer throw away the word that was already prefetched and execute a no-operation in its place, so a transfer costs two instruction cycles. The decoder, ALU and memories are not part of the block; they connect through plain ports.

Top module: `quad_phase_seq`

## Requirements
- R1: `qPhase` is one-hot and steps Q1 (bit 0), Q2 (bit 1), Q3 (bit 2), Q4 (bit 3), one oscillator clock each, then back to Q1. It is all-zero while `rst` is high. The first Q1 starts at the first clock edge at which `rst` is sampled low.
- R2: At the end of Q1 the fetch address takes the program counter value and the program counter increments. `progAddr` changes only at that edge (or at reset).
- R3: At the end of Q4 the instruction register loads `instrData`, which is the word at `progAddr`. That word is shown on `instrReg` for the whole next instruction cycle, and `instrReg` changes at no other edge except reset.
- R4: With no transfer, consecutive instruction cycles fetch consecutive addresses. Each fetched word executes in the cycle right after its fetch.
- R5: In an instruction cycle whose `instrReg` holds a real (not flushed) instruction, `dataRdStb` is high exactly in Q2 and `dataWrStb` is high exactly in Q4. In a flushed cycle neither strobe is high.
- R6: A `branchReq` sampled at the end of Q4 of a real instruction cycle loads the program counter with `branchTarget`. The prefetched word is discarded, `instrReg` becomes the no-operation word 14'h0000 with `execValid` low for the next cycle, and that cycle fetches from `branchTarget`.
- R7: A `branchReq` during a flushed (no-operation) cycle is ignored, and fetching continues sequentially.
- R8: `progAddr` is the low 12 bits of the 13-bit fetch address. Fetching past 0x0FFF wraps to 0x000, and a target such as 0x1ABC fetches from 0xABC.
- R9: Synchronous active-high `rst`, from any phase, clears the program counter, `retAddr`, `irqAck` and `execValid`, loads `instrReg` with 14'h0000, and returns the phase counter to the clock before Q1.
- R10: An `irqReq` sampled at the end of Q4 with no branch taken in that cycle does the following: loads the program counter with 0x0004, flushes the prefetched word exactly as R6 does, sets `retAddr` to the address of the discarded word, and raises `irqAck` for the single following clock (the next Q1).
- R11: If a branch and an interrupt arrive at the same boundary, the branch wins. An interrupt request still held at the next boundary is then taken, with `retAddr` equal to the branch target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| instrData | input | 14 | Program memory word at `progAddr` |
| branchReq | input | 1 | Control transfer request from execute logic, sampled at end of Q4 |
| branchTarget | input | 13 | Target address for the transfer |
| irqReq | input | 1 | Interrupt request, sampled at end of Q4 |
| qPhase | output | 4 | One-hot phase strobes, bit 0 = Q1 … bit 3 = Q4 |
| progAddr | output | 12 | Program memory fetch address |
| instrReg | output | 14 | Instruction under execution |
| execValid | output | 1 | Current instruction is real, not a flushed bubble |
| dataRdStb | output | 1 | Data memory operand read slot (Q2) |
| dataWrStb | output | 1 | Data memory destination write slot (Q4) |
| irqAck | output | 1 | One-clock pulse when an interrupt has been taken |
| retAddr | output | 13 | Return address captured on interrupt acceptance |

## Verification
The assertions watch the invariant timing on every cycle. They check that the phase strobes are one-hot and rotate in order, that the fetch address and the instruction register move only at their own phase edges, that each read slot is followed two clocks later by its write slot, that flushed cycles raise no data strobe, and that an accepted interrupt shows a no-operation and then the vector address. Only the bench scenarios can show the values themselves. These are the exact address sequence across wrap-around, that branches during bubbles are ignored, that a branch wins over a simultaneous interrupt, and the return address captured in each case. A random mix of transfers is compared against an instruction-level model, alongside directed cases.

// File: rtl/quad_seq_pkg.sv
package quad_seq_pkg;
  localparam int PHASES = 4;
  localparam int PH_W = $clog2(PHASES);
  localparam int RD_SLOT = 1;
  localparam int WR_SLOT = PHASES - 1;

  typedef struct packed {
    logic [PHASES-1:0] q;
    logic              loadTarget;
    logic              loadVector;
  } seqStrobes_t;
endpackage

// File: rtl/quad_seq_ctrl.sv
module quad_seq_ctrl
  import quad_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        branchReq,
  input  logic        irqReq,
  output seqStrobes_t strobes,
  output logic        execValid,
  output logic        dataRdStb,
  output logic        dataWrStb,
  output logic        irqAck
);
  logic              armed;
  logic [PH_W-1:0]   phaseCnt;
  logic              bubble;
  logic [PHASES-1:0] phaseHot;
  logic              takeBranch;
  logic              takeIrq;

  generate
    for (genvar i = 0; i < PHASES; i++) begin : g_phaseDec
      assign phaseHot[i] = armed && (phaseCnt == PH_W'(i));
    end
  endgenerate

  // Transfers are resolved only at the instruction-cycle boundary.
  assign takeBranch = phaseHot[WR_SLOT] & ~bubble & branchReq;
  assign takeIrq    = phaseHot[WR_SLOT] & ~takeBranch & irqReq;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      phaseCnt <= PH_W'(PHASES - 1);
      bubble   <= 1'b1;
      irqAck   <= 1'b0;
    end else begin
      armed    <= 1'b1;
      phaseCnt <= phaseCnt + 1'b1;
      irqAck   <= takeIrq;
      if (phaseHot[WR_SLOT]) bubble <= takeBranch | takeIrq;
    end
  end

  assign strobes.q          = phaseHot;
  assign strobes.loadTarget = takeBranch;
  assign strobes.loadVector = takeIrq;
  assign execValid          = ~bubble;
  assign dataRdStb          = phaseHot[RD_SLOT] & ~bubble;
  assign dataWrStb          = phaseHot[WR_SLOT] & ~bubble;
endmodule

// File: rtl/quad_seq_datapath.sv
module quad_seq_datapath
  import quad_seq_pkg::*;
#(
  parameter int PC_W       = 13,
  parameter int ADDR_W     = 12,
  parameter int INSTR_W    = 14,
  parameter int NOP_WORD   = 0,
  parameter int IRQ_VECTOR = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  seqStrobes_t        strobes,
  input  logic [PC_W-1:0]    branchTarget,
  input  logic [INSTR_W-1:0] instrData,
  output logic [ADDR_W-1:0]  progAddr,
  output logic [INSTR_W-1:0] instrReg,
  output logic [PC_W-1:0]    retAddr
);
  localparam logic [INSTR_W-1:0] NOP_INSTR = INSTR_W'(NOP_WORD);
  localparam logic [PC_W-1:0]    VEC_ADDR  = PC_W'(IRQ_VECTOR);

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] fetchAddr;
  logic            flush;

  assign flush = strobes.loadTarget | strobes.loadVector;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      fetchAddr <= '0;
      instrReg  <= NOP_INSTR;
      retAddr   <= '0;
    end else begin
      if (strobes.q[0]) begin
        fetchAddr <= pc;
        pc        <= pc + 1'b1;
      end
      if (strobes.q[WR_SLOT]) begin
        if (strobes.loadTarget) begin
          pc <= branchTarget;
        end else if (strobes.loadVector) begin
          pc      <= VEC_ADDR;
          retAddr <= fetchAddr;
        end
        instrReg <= flush ? NOP_INSTR : instrData;
      end
    end
  end

  // Only the implemented space is addressed; upper bits wrap.
  assign progAddr = fetchAddr[ADDR_W-1:0];
endmodule

// File: rtl/quad_phase_seq.sv
module quad_phase_seq
  import quad_seq_pkg::*;
#(
  parameter int PC_W       = 13,
  parameter int ADDR_W     = 12,
  parameter int INSTR_W    = 14,
  parameter int NOP_WORD   = 0,
  parameter int IRQ_VECTOR = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instrData,
  input  logic               branchReq,
  input  logic [PC_W-1:0]    branchTarget,
  input  logic               irqReq,
  output logic [PHASES-1:0]  qPhase,
  output logic [ADDR_W-1:0]  progAddr,
  output logic [INSTR_W-1:0] instrReg,
  output logic               execValid,
  output logic               dataRdStb,
  output logic               dataWrStb,
  output logic               irqAck,
  output logic [PC_W-1:0]    retAddr
);
  seqStrobes_t strobes;

  quad_seq_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .branchReq (branchReq),
    .irqReq    (irqReq),
    .strobes   (strobes),
    .execValid (execValid),
    .dataRdStb (dataRdStb),
    .dataWrStb (dataWrStb),
    .irqAck    (irqAck)
  );

  quad_seq_datapath #(
    .PC_W       (PC_W),
    .ADDR_W     (ADDR_W),
    .INSTR_W    (INSTR_W),
    .NOP_WORD   (NOP_WORD),
    .IRQ_VECTOR (IRQ_VECTOR)
  ) dp_i (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .branchTarget (branchTarget),
    .instrData    (instrData),
    .progAddr     (progAddr),
    .instrReg     (instrReg),
    .retAddr      (retAddr)
  );

  assign qPhase = strobes.q;
endmodule

// File: rtl/quad_phase_seq_chk.sv
module quad_phase_seq_chk #(
  parameter int PC_W       = 13,
  parameter int ADDR_W     = 12,
  parameter int INSTR_W    = 14,
  parameter int NOP_WORD   = 0,
  parameter int IRQ_VECTOR = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [3:0]         qPhase,
  input logic [ADDR_W-1:0]  progAddr,
  input logic [INSTR_W-1:0] instrReg,
  input logic               execValid,
  input logic               dataRdStb,
  input logic               dataWrStb,
  input logic               irqAck
);
  assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(qPhase));
  assert_phase_q1_q2_R1: assert property (@(posedge clk) disable iff (rst)
    qPhase[0] |=> qPhase[1]);
  assert_phase_q2_q3_R1: assert property (@(posedge clk) disable iff (rst)
    qPhase[1] |=> qPhase[2]);
  assert_phase_q3_q4_R1: assert property (@(posedge clk) disable iff (rst)
    qPhase[2] |=> qPhase[3]);
  assert_phase_q4_q1_R1: assert property (@(posedge clk) disable iff (rst)
    qPhase[3] |=> qPhase[0]);

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !qPhase[0] |=> $stable(progAddr));

  assert_ir_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !qPhase[3] |=> $stable(instrReg));

  assert_rd_then_wr_R5: assert property (@(posedge clk) disable iff (rst)
    dataRdStb |-> ##2 dataWrStb);
  assert_no_strobe_in_bubble_R5: assert property (@(posedge clk) disable iff (rst)
    !execValid |-> (!dataRdStb && !dataWrStb));

  assert_irq_flush_R10: assert property (@(posedge clk) disable iff (rst)
    irqAck |-> (!execValid && instrReg == INSTR_W'(NOP_WORD)));
  assert_irq_vector_R10: assert property (@(posedge clk) disable iff (rst)
    irqAck |=> (progAddr == ADDR_W'(IRQ_VECTOR)));
endmodule

bind quad_phase_seq quad_phase_seq_chk #(
  .PC_W       (PC_W),
  .ADDR_W     (ADDR_W),
  .INSTR_W    (INSTR_W),
  .NOP_WORD   (NOP_WORD),
  .IRQ_VECTOR (IRQ_VECTOR)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .qPhase    (qPhase),
  .progAddr  (progAddr),
  .instrReg  (instrReg),
  .execValid (execValid),
  .dataRdStb (dataRdStb),
  .dataWrStb (dataWrStb),
  .irqAck    (irqAck)
);

// File: tb/quad_phase_seq_tb_top.sv
module quad_phase_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [13:0] NOP = 14'h0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] instrData;
  logic        branchReq = 1'b0;
  logic [12:0] branchTarget = '0;
  logic        irqReq = 1'b0;
  logic [3:0]  qPhase;
  logic [11:0] progAddr;
  logic [13:0] instrReg;
  logic        execValid, dataRdStb, dataWrStb, irqAck;
  logic [12:0] retAddr;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [13:0] memWord(logic [11:0] a);
    return 14'(({2'b0, a} * 14'd37 + 14'd5) ^ 14'h2A5) | 14'h0001;
  endfunction

  assign instrData = memWord(progAddr);

  quad_phase_seq dut_i (
    .clk(clk), .rst(rst), .instrData(instrData), .branchReq(branchReq),
    .branchTarget(branchTarget), .irqReq(irqReq), .qPhase(qPhase),
    .progAddr(progAddr), .instrReg(instrReg), .execValid(execValid),
    .dataRdStb(dataRdStb), .dataWrStb(dataWrStb), .irqAck(irqAck),
    .retAddr(retAddr)
  );

  // Instruction-level reference state
  logic [12:0] mPc, mFetch, mRet;
  logic [13:0] mIr;
  bit          mBubble, mAck;

  task automatic checkEq(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1; branchReq = 1'b0; irqReq = 1'b0;
    repeat (2) @(negedge clk);
    checkEq("R9", "qPhase in reset", qPhase, 0);
    checkEq("R9", "instrReg in reset", instrReg, NOP);
    checkEq("R9", "execValid in reset", execValid, 0);
    checkEq("R9", "irqAck in reset", irqAck, 0);
    checkEq("R9", "retAddr in reset", retAddr, 0);
    checkEq("R9", "dataRdStb in reset", dataRdStb, 0);
    rst = 1'b0;
    #1;
    checkEq("R1", "qPhase before Q1", qPhase, 0);
    @(negedge clk);
    mPc = '0; mFetch = '0; mRet = '0; mIr = NOP; mBubble = 1; mAck = 0;
  endtask

  // Called at the negedge inside Q1; returns at the negedge inside the next Q1.
  task automatic runCycle(string tag, bit br, logic [12:0] tgt, bit irq);
    bit takeBr, takeIrq;
    checkEq("R1", "qPhase Q1", qPhase, 4'b0001);
    checkEq("R10", "irqAck pulse", irqAck, mAck);
    if (mAck) checkEq("R10", "retAddr", retAddr, mRet);
    mFetch = mPc;
    mPc = mPc + 13'd1;
    @(negedge clk);
    checkEq("R1", "qPhase Q2", qPhase, 4'b0010);
    checkEq(tag, "progAddr", progAddr, mFetch[11:0]);
    checkEq("R3", "instrReg", instrReg, mIr);
    checkEq("R6", "execValid", execValid, !mBubble);
    checkEq("R5", "dataRdStb Q2", dataRdStb, !mBubble);
    checkEq("R10", "irqAck single clock", irqAck, 0);
    branchReq = br; branchTarget = tgt; irqReq = irq;
    @(negedge clk);
    checkEq("R5", "strobes Q3", {dataRdStb, dataWrStb}, 0);
    @(negedge clk);
    checkEq("R1", "qPhase Q4", qPhase, 4'b1000);
    checkEq("R5", "dataWrStb Q4", dataWrStb, !mBubble);
    takeBr  = br && !mBubble;
    takeIrq = !takeBr && irq;
    mAck = takeIrq;
    if (takeBr) begin
      mPc = tgt; mIr = NOP; mBubble = 1;
    end else if (takeIrq) begin
      mRet = mFetch; mPc = 13'd4; mIr = NOP; mBubble = 1;
    end else begin
      mIr = memWord(mFetch[11:0]); mBubble = 0;
    end
    @(negedge clk);
    branchReq = 1'b0; irqReq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    doReset();
    for (int i = 0; i < 5; i++) runCycle("R4", 0, '0, 0);
    // Jump near the top of the space, then try a branch from the bubble
    runCycle("R4", 1, 13'h0FFE, 0);
    runCycle("R6", 1, 13'h0500, 0);
    runCycle("R7", 0, '0, 0);
    runCycle("R8", 0, '0, 0);
    runCycle("R8", 1, 13'h1ABC, 0);
    runCycle("R6", 0, '0, 0);
    runCycle("R8", 0, '0, 0);
    // Interrupt on a normal boundary
    runCycle("R4", 0, '0, 1);
    runCycle("R10", 0, '0, 0);
    runCycle("R10", 0, '0, 0);
    // Branch and interrupt together: branch first, interrupt next boundary
    runCycle("R4", 1, 13'h0123, 1);
    runCycle("R11", 0, '0, 1);
    runCycle("R11", 0, '0, 0);
    runCycle("R11", 0, '0, 0);
    // Reset in the middle of Q2
    @(negedge clk);
    doReset();
    runCycle("R9", 0, '0, 0);
    runCycle("R9", 0, '0, 0);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      bit br, irq;
      logic [12:0] tgt;
      br  = ($urandom % 100) < 20;
      irq = ($urandom % 100) < 15;
      tgt = 13'($urandom);
      runCycle("R4", br, tgt, irq);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule